// File: doc/BRIEF.md
# Compressed Byte Memory Port

This block sits between an image codec core and an external byte-wide memory that holds the compressed bit stream. A 64-entry byte FIFO buffers the stream. In compression mode the core pushes bytes into the FIFO and the port writes them out to memory. In decompression mode the port reads bytes from memory into the FIFO, and the core pops them. The port waits whenever the FIFO has no room.

A host sets a 20-bit start address, one wait-state count for writes and another for reads, and the direction. It then pulses `start_i`. The port walks the addresses upward from the start address, one byte per access, and wraps at 2^20. The host pulses `frame_end_i` to close the frame. When the frame closes, the port records the address of the last byte it moved in a read-only end-address output and drops `busy_o`. A status byte reports FIFO full in bit 0 and FIFO empty in bit 1.

The sequencer has five states:

- **IDLE**: the port waits. IDLE goes to RUN on `start_i`.
- **RUN**: the port chooses the next action.
  - In compression mode, RUN goes to WRITE when the FIFO holds data. It goes to FINISH once the frame has ended and the FIFO is empty.
  - In decompression mode, RUN goes to FINISH once the frame has ended. Otherwise it goes to READ when the FIFO has room.
- **WRITE** and **READ**: one memory access each. Each returns to RUN when its wait count runs out.
- **FINISH**: records the end address and returns to IDLE.

Top module: `cmp_mem_port`

## Requirements
- R1: After reset, `fifo_status_o` equals 8'h02 (empty bit 1 set, full bit 0 clear, bits 7..2 zero), `busy_o` is low and `mem_cs_o`, `mem_oe_o` and `mem_we_o` are low.
- R2: The first access after `start_i` uses the start address. Each later access uses the previous address plus one.
- R3: A write access holds `mem_cs_o` and `mem_we_o` high for exactly `wr_wait_i`+1 cycles, with address and data stable throughout. The strobe then drops for at least one cycle.
- R4: A read access holds `mem_cs_o` and `mem_oe_o` high for exactly `rd_wait_i`+1 cycles with a stable address. The byte on `mem_rdata_i` in the last cycle of the access enters the FIFO.
- R5: In compression mode (`mode_i`=0), bytes pushed by the core are written to memory in push order, each exactly once.
- R6: In decompression mode (`mode_i`=1), no read starts while the FIFO holds 64 bytes. Reading resumes once the core pops a byte.
- R7: The address after 20'hFFFFF is 20'h00000.
- R8: After the frame ends, `end_addr_o` holds the address of the last byte moved and `busy_o` falls. In compression mode this happens only after the FIFO has drained.
- R9: Status bit 0 is set exactly when the FIFO holds 64 bytes and bit 1 exactly when it holds none. A push to a full FIFO is dropped.
- R10: The direction latched at the last start gates the core side. `pop_i` has no effect in compression mode and `push_i` has no effect in decompression mode.
- R11: `mem_oe_o` and `mem_we_o` are never high together, and the chip select stays low while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Pulse that starts a frame |
| mode_i | input | 1 | Direction: 0 compress (FIFO to memory), 1 decompress (memory to FIFO) |
| frame_end_i | input | 1 | Pulse that closes the running frame |
| start_addr_i | input | 20 | First memory address of the frame |
| wr_wait_i | input | 4 | Extra cycles per write access |
| rd_wait_i | input | 4 | Extra cycles per read access |
| push_i | input | 1 | Core pushes a byte (compression) |
| push_data_i | input | 8 | Byte pushed by the core |
| pop_i | input | 1 | Core pops the head byte (decompression) |
| pop_data_o | output | 8 | Head byte of the FIFO |
| fifo_status_o | output | 8 | Bit 0 full, bit 1 empty, other bits zero |
| busy_o | output | 1 | Frame in progress |
| end_addr_o | output | 20 | Address of the last byte moved in the last frame |
| mem_cs_o | output | 1 | Memory chip select |
| mem_oe_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 20 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |

## Verification
The bench targets the strobe length with zero and with nonzero wait counts; a design with an off-by-one counter would produce strobes one cycle short or long. It runs a frame across the top of the address space; a design without the wrap would leave the 20-bit range or corrupt the end address. It lets the FIFO fill during decompression and checks that reads stop at exactly 64 bytes; a design with a bad full test would overrun or stop one byte early. It also checks the frame close: a compression frame must not close while the FIFO still holds data, and the end address must be the last address used, not the next one.

// File: rtl/cmp_mem_port_pkg.sv
package cmp_mem_port_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WRITE,
        ST_READ,
        ST_FINISH
    } seq_state_t;

    localparam logic MODE_COMPRESS   = 1'b0;
    localparam logic MODE_DECOMPRESS = 1'b1;
endpackage

// File: rtl/cmp_mem_fifo.sv
module cmp_mem_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              do_push, do_pop;

    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = store[rptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            end
            if (do_pop) begin
                rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
            if (do_push && !do_pop) begin
                count_q <= count_q + 1'b1;
            end else if (do_pop && !do_push) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr_q] <= push_data_i;
        end
    end
endmodule

// File: rtl/cmp_mem_seq.sv
module cmp_mem_seq
    import cmp_mem_port_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              frame_end_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [WS_W-1:0]   wr_wait_i,
    input  logic [WS_W-1:0]   rd_wait_i,
    input  logic              fifo_full_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_head_i,
    output logic              port_push_o,
    output logic              port_pop_o,
    output logic              mode_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] end_addr_o,
    output logic              mem_cs_o,
    output logic              mem_oe_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, end_addr_q;
    logic [WS_W-1:0]   cnt_q;
    logic [DATA_W-1:0] wdata_q;
    logic              mode_q, end_req_q;
    logic              cnt_done;

    assign cnt_done = (cnt_q == '0);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (mode_q == MODE_COMPRESS) begin
                    if (!fifo_empty_i)  state_d = ST_WRITE;
                    else if (end_req_q) state_d = ST_FINISH;
                end else begin
                    if (end_req_q)         state_d = ST_FINISH;
                    else if (!fifo_full_i) state_d = ST_READ;
                end
            end
            ST_WRITE: begin
                if (cnt_done) state_d = ST_RUN;
            end
            ST_READ: begin
                if (cnt_done) state_d = ST_RUN;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            end_addr_q <= '0;
            cnt_q      <= '0;
            wdata_q    <= '0;
            mode_q     <= MODE_COMPRESS;
            end_req_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_IDLE && frame_end_i) begin
                end_req_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q    <= start_addr_i;
                        mode_q    <= mode_i;
                        end_req_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (state_d == ST_WRITE) begin
                        wdata_q <= fifo_head_i;
                        cnt_q   <= wr_wait_i;
                    end else if (state_d == ST_READ) begin
                        cnt_q <= rd_wait_i;
                    end
                end
                ST_WRITE, ST_READ: begin
                    if (cnt_done) addr_q <= addr_q + 1'b1;
                    else          cnt_q  <= cnt_q - 1'b1;
                end
                ST_FINISH: end_addr_q <= addr_q - 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_cs_o    = (state_q == ST_WRITE) || (state_q == ST_READ);
        mem_we_o    = (state_q == ST_WRITE);
        mem_oe_o    = (state_q == ST_READ);
        mem_addr_o  = addr_q;
        mem_wdata_o = wdata_q;
        port_pop_o  = (state_q == ST_RUN) && (state_d == ST_WRITE);
        port_push_o = (state_q == ST_READ) && cnt_done;
        busy_o      = (state_q != ST_IDLE);
        mode_o      = mode_q;
        end_addr_o  = end_addr_q;
    end
endmodule

// File: rtl/cmp_mem_port.sv
module cmp_mem_port
    import cmp_mem_port_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              frame_end_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [WS_W-1:0]   wr_wait_i,
    input  logic [WS_W-1:0]   rd_wait_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic [7:0]        fifo_status_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] end_addr_o,
    output logic              mem_cs_o,
    output logic              mem_oe_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    logic              f_push, f_pop, f_full, f_empty;
    logic [DATA_W-1:0] f_wdata, f_head;
    logic              port_push, port_pop, mode_q;

    // The latched direction decides which side owns each FIFO port
    assign f_push  = (mode_q == MODE_DECOMPRESS) ? port_push   : push_i;
    assign f_wdata = (mode_q == MODE_DECOMPRESS) ? mem_rdata_i : push_data_i;
    assign f_pop   = (mode_q == MODE_DECOMPRESS) ? pop_i       : port_pop;

    assign pop_data_o    = f_head;
    assign fifo_status_o = {6'b0, f_empty, f_full};

    cmp_mem_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_i     (f_push),
        .push_data_i(f_wdata),
        .pop_i      (f_pop),
        .head_o     (f_head),
        .full_o     (f_full),
        .empty_o    (f_empty)
    );

    cmp_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .frame_end_i (frame_end_i),
        .start_addr_i(start_addr_i),
        .wr_wait_i   (wr_wait_i),
        .rd_wait_i   (rd_wait_i),
        .fifo_full_i (f_full),
        .fifo_empty_i(f_empty),
        .fifo_head_i (f_head),
        .port_push_o (port_push),
        .port_pop_o  (port_pop),
        .mode_o      (mode_q),
        .busy_o      (busy_o),
        .end_addr_o  (end_addr_o),
        .mem_cs_o    (mem_cs_o),
        .mem_oe_o    (mem_oe_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );
endmodule

// File: rtl/cmp_mem_port_chk.sv
module cmp_mem_port_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_cs_o,
    input logic              mem_oe_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              busy_o,
    input logic [7:0]        fifo_status_o
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(mem_oe_o && mem_we_o)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_cs_o); // R11
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_cs_o && $past(mem_cs_o)) |-> $stable(mem_addr_o)); // R3
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> $stable(mem_wdata_o)); // R3
    AST_FULL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (fifo_status_o[0] && !mem_cs_o) |=> !mem_oe_o); // R6
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_status_o[0] && fifo_status_o[1])); // R9
endmodule

bind cmp_mem_port cmp_mem_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_cs_o     (mem_cs_o),
    .mem_oe_o     (mem_oe_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .busy_o       (busy_o),
    .fifo_status_o(fifo_status_o)
);

// File: tb/cmp_mem_port_tb.sv
module cmp_mem_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 0, mode_i = 0, frame_end_i = 0;
    logic [19:0] start_addr_i = '0;
    logic [3:0]  wr_wait_i = '0, rd_wait_i = '0;
    logic        push_i = 0, pop_i = 0;
    logic [7:0]  push_data_i = '0;
    logic [7:0]  pop_data_o, fifo_status_o, mem_wdata_o, mem_rdata_i;
    logic        busy_o, mem_cs_o, mem_oe_o, mem_we_o;
    logic [19:0] end_addr_o, mem_addr_o;

    int checks = 0, errors = 0;
    logic [7:0]  exp_q[$];
    logic [19:0] wr_next, rd_next, pop_next;
    int          rd_count = 0, wr_count = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [19:0] a);
        return a[7:0] ^ 8'h3C ^ {4'h0, a[19:16]};
    endfunction

    assign mem_rdata_i = (mem_cs_o && mem_oe_o) ? mem_model(mem_addr_o) : 8'h00;

    cmp_mem_port u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .frame_end_i(frame_end_i), .start_addr_i(start_addr_i),
        .wr_wait_i(wr_wait_i), .rd_wait_i(rd_wait_i), .push_i(push_i),
        .push_data_i(push_data_i), .pop_i(pop_i), .pop_data_o(pop_data_o),
        .fifo_status_o(fifo_status_o), .busy_o(busy_o), .end_addr_o(end_addr_o),
        .mem_cs_o(mem_cs_o), .mem_oe_o(mem_oe_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write monitor: scoreboard pops expected bytes as writes complete
    int wlen = 0;
    logic [19:0] waddr;
    logic [7:0]  wdat;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we_o) begin
                if (wlen == 0) begin waddr = mem_addr_o; wdat = mem_wdata_o; end
                wlen++;
            end else if (wlen != 0) begin
                wr_count++;
                chk(wlen == int'(wr_wait_i) + 1, "R3 write strobe length", wlen, int'(wr_wait_i) + 1);
                chk(waddr == wr_next, "R2 write address", waddr, wr_next);
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", wdat, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(wdat == e, "R5 write data order", wdat, e);
                end
                wr_next = wr_next + 20'd1;
                wlen = 0;
            end
        end
    end

    // Read monitor
    int rlen = 0;
    logic [19:0] raddr;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_oe_o) begin
                if (rlen == 0) raddr = mem_addr_o;
                rlen++;
            end else if (rlen != 0) begin
                rd_count++;
                chk(rlen == int'(rd_wait_i) + 1, "R4 read strobe length", rlen, int'(rd_wait_i) + 1);
                chk(raddr == rd_next, "R2 read address", raddr, rd_next);
                rd_next = rd_next + 20'd1;
                rlen = 0;
            end
        end
    end

    task automatic push_byte(input logic [7:0] d, input bit expect_write);
        @(negedge clk);
        push_i = 1; push_data_i = d;
        if (expect_write) exp_q.push_back(d);
        @(negedge clk);
        push_i = 0;
    endtask

    task automatic pop_byte();
        @(negedge clk);
        chk(fifo_status_o[1] == 1'b0, "R4 fifo has data to pop", fifo_status_o, 0);
        chk(pop_data_o == mem_model(pop_next), "R4 read byte into fifo", pop_data_o, mem_model(pop_next));
        pop_next = pop_next + 20'd1;
        pop_i = 1;
        @(negedge clk);
        pop_i = 0;
    endtask

    task automatic pulse_start(input logic m, input logic [19:0] a);
        @(negedge clk);
        mode_i = m; start_addr_i = a; start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic end_frame();
        @(negedge clk);
        frame_end_i = 1;
        @(negedge clk);
        frame_end_i = 0;
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(fifo_status_o == 8'h02, "R1 reset status", fifo_status_o, 8'h02);
        chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
        chk({mem_cs_o, mem_oe_o, mem_we_o} == 3'b000, "R1 reset strobes", {mem_cs_o, mem_oe_o, mem_we_o}, 0);

        // Compression, two wait states, bytes queued before start
        wr_wait_i = 4'd2; wr_next = 20'h01230;
        for (int i = 0; i < 5; i++) push_byte(8'hA0 + 8'(i * 7), 1'b1);
        pulse_start(1'b0, 20'h01230);
        end_frame();
        chk(end_addr_o == 20'h01234, "R8 end address compress", end_addr_o, 20'h01234);
        chk(fifo_status_o == 8'h02, "R8 fifo drained at close", fifo_status_o, 8'h02);
        chk(exp_q.size() == 0, "R5 all bytes written", exp_q.size(), 0);

        // Zero wait states across the top of the address space, pushes during run
        wr_wait_i = 4'd0; wr_next = 20'hFFFFE;
        pulse_start(1'b0, 20'hFFFFE);
        for (int i = 0; i < 4; i++) push_byte(8'h11 * 8'(i + 1), 1'b1);
        end_frame();
        chk(end_addr_o == 20'h00001, "R7 wrap end address", end_addr_o, 20'h00001);
        chk(exp_q.size() == 0, "R5 wrap bytes written", exp_q.size(), 0);

        // Fill to 64 while idle, overflow dropped, pop ignored in compress mode
        for (int i = 0; i < 64; i++) push_byte(8'(i * 3 + 1), 1'b1);
        @(negedge clk);
        chk(fifo_status_o == 8'h01, "R9 full status", fifo_status_o, 8'h01);
        push_byte(8'hEE, 1'b0);
        @(negedge clk); pop_i = 1; @(negedge clk); pop_i = 0;
        @(negedge clk);
        chk(fifo_status_o == 8'h01, "R10 pop ignored in compress mode", fifo_status_o, 8'h01);
        wr_wait_i = 4'd1; wr_next = 20'h00100; wr_count = 0;
        pulse_start(1'b0, 20'h00100);
        end_frame();
        chk(wr_count == 64, "R9 overflow byte dropped", wr_count, 64);
        chk(end_addr_o == 20'h0013F, "R8 end address after full drain", end_addr_o, 20'h0013F);

        // Decompression with stall on full
        rd_wait_i = 4'd3; rd_next = 20'h40000; pop_next = 20'h40000; rd_count = 0;
        pulse_start(1'b1, 20'h40000);
        repeat (400) @(negedge clk);
        chk(fifo_status_o == 8'h01, "R6 fifo full after reads", fifo_status_o, 8'h01);
        chk(rd_count == 64, "R6 reads stop at 64", rd_count, 64);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (mem_oe_o) seen++; end
            chk(seen == 0, "R6 no read while full", seen, 0);
        end
        for (int i = 0; i < 10; i++) pop_byte();
        repeat (100) @(negedge clk);
        chk(rd_count == 74, "R6 reads resume after pops", rd_count, 74);
        end_frame();
        chk(end_addr_o == 20'h40049, "R8 end address decompress", end_addr_o, 20'h40049);
        for (int i = 0; i < 64; i++) pop_byte();
        @(negedge clk);
        chk(fifo_status_o == 8'h02, "R9 empty after drain", fifo_status_o, 8'h02);
        push_byte(8'h77, 1'b0);
        @(negedge clk);
        chk(fifo_status_o == 8'h02, "R10 push ignored in decompress mode", fifo_status_o, 8'h02);
        chk(busy_o == 1'b0 && mem_cs_o == 1'b0, "R11 quiet when idle", {busy_o, mem_cs_o}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule